// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one analog-to-digital conversion at a time. It runs on a clock at twice the converter clock, so one tick of `clk` is half a converter cycle. A start request is accepted only while the block is idle. On acceptance the block captures the sampling-time setting and the channel number. It then holds the sample-and-hold enable high for a programmable window and spends a fixed conversion latency with the enable low. At the end it latches the 12-bit code from the external converter core into a zero-padded 16-bit word and pulses `done`.

All channels share one sampling setting `S`. The window lasts 1.5 + S converter cycles, which is 3 + 2·S ticks. The latency after it is 12.5 converter cycles, which is 25 ticks. A whole conversion therefore keeps `busy` high for 28 + 2·S ticks. With S = 0 that is 14 converter cycles, or 1 µs at a 14 MHz converter clock.

Top module: `adc_conv_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `busy`, `sample_en` and `done` low, `result` zero and `ch_tag` zero in the following cycle, including when the reset arrives mid-conversion.
- R2: A `start` seen high at a clock edge while the block is idle makes `busy` and `sample_en` high in the next cycle, with `ch_tag` equal to the `chan` value present at that edge.
- R3: `sample_en` stays high for exactly 3 + 2·S consecutive ticks, where S is the 8-bit `samp_set` value captured with the accepted start.
- R4: After `sample_en` falls, `busy` stays high with `sample_en` low for exactly 25 ticks.
- R5: `done` is high for exactly one cycle, namely the first cycle in which `busy` is low after a conversion.
- R6: In the `done` cycle, `result` equals {4'b0000, raw_code}, where raw_code is the value of `raw_code` during the last busy cycle. `result` then holds this value until the next `done`.
- R7: A `start` that arrives while `busy` is high is ignored. The timing of the running conversion and `ch_tag` are unaffected.
- R8: Changes on `samp_set` and `chan` while busy have no effect on the running conversion or on `ch_tag`.
- R9: A `start` held high during the `done` cycle is accepted. `sample_en` and `busy` rise in the next cycle, and `done` falls.
- R10: With S = 0, one conversion keeps `busy` high for 28 ticks, which is 14 converter cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock (one tick = half a converter cycle) |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted only when idle |
| samp_set | input | 8 | Sampling-time setting S; window = 3 + 2·S ticks |
| chan | input | 4 | Channel number tagged onto the conversion |
| raw_code | input | 12 | Code from the external converter core |
| sample_en | output | 1 | Sample-and-hold enable during the sampling window |
| busy | output | 1 | High while sampling or converting |
| done | output | 1 | One-cycle pulse marking a fresh result |
| ch_tag | output | 4 | Channel captured with the running or last conversion |
| result | output | 16 | Right-aligned code with the top four bits zero |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle. The `done` cycle is also the first idle cycle, so a `start` held high there launches a new window at once. The bench provokes this by chaining conversions back to back, driving `start` in the very cycle it observes `done`. It then judges the next cycle: `done` must have dropped, `sample_en` and `busy` must be high, `ch_tag` must carry the new channel, and the earlier result must still be intact. Random `start`, `samp_set` and `chan` noise injected throughout each conversion checks that only an idle-cycle request is taken.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_e;

    // Length of the sampling window in half-cycle ticks.
    function automatic int unsigned window_ticks(int unsigned setting, int unsigned base_ticks);
        return base_ticks + 2 * setting;
    endfunction

    function automatic int unsigned max_int(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_tick_counter.sv
module adc_tick_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign at_zero = (remain == '0);
endmodule

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SET_W          = 8,
    parameter int CH_W           = 4,
    parameter int CNT_W          = 10,
    parameter int MIN_SAMP_TICKS = 3,
    parameter int LAT_TICKS      = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SET_W-1:0] samp_set,
    input  logic [CH_W-1:0]  chan,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             sample_en,
    output logic             busy,
    output logic             capture,
    output logic [CH_W-1:0]  ch_tag
);
    localparam logic [CNT_W-1:0] SAMP_BASE_M1 = CNT_W'(MIN_SAMP_TICKS - 1);
    localparam logic [CNT_W-1:0] LAT_M1       = CNT_W'(LAT_TICKS - 1);

    phase_e           phase_q, phase_d;
    logic [CH_W-1:0]  tag_q;
    logic             accept;

    assign accept = (phase_q == PH_IDLE) && start;

    always_comb begin
        phase_d  = phase_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        capture  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d  = PH_SAMPLE;
                    cnt_load = 1'b1;
                    cnt_val  = SAMP_BASE_M1 + (CNT_W'(samp_set) << 1);
                end
            end
            PH_SAMPLE: begin
                if (cnt_zero) begin
                    phase_d  = PH_CONV;
                    cnt_load = 1'b1;
                    cnt_val  = LAT_M1;
                end
            end
            PH_CONV: begin
                if (cnt_zero) begin
                    phase_d = PH_IDLE;
                    capture = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            tag_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                tag_q <= chan;
            end
        end
    end

    assign sample_en = (phase_q == PH_SAMPLE);
    assign busy      = (phase_q != PH_IDLE);
    assign ch_tag    = tag_q;
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
    parameter int CODE_W = 12,
    parameter int RES_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [CODE_W-1:0] raw_code,
    output logic [RES_W-1:0]  result,
    output logic              done
);
    localparam int PAD_W = RES_W - CODE_W;

    logic [RES_W-1:0] formatted;

    generate
        if (PAD_W > 0) begin : g_pad
            assign formatted = {{PAD_W{1'b0}}, raw_code};
        end else begin : g_nopad
            assign formatted = raw_code[RES_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= capture;
            if (capture) begin
                result <= formatted;
            end
        end
    end
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
    import adc_seq_pkg::*;
#(
    parameter int SET_W          = 8,
    parameter int CH_W           = 4,
    parameter int CODE_W         = 12,
    parameter int RES_W          = 16,
    parameter int MIN_SAMP_TICKS = 3,
    parameter int LAT_TICKS      = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SET_W-1:0]  samp_set,
    input  logic [CH_W-1:0]   chan,
    input  logic [CODE_W-1:0] raw_code,
    output logic              sample_en,
    output logic              busy,
    output logic              done,
    output logic [CH_W-1:0]   ch_tag,
    output logic [RES_W-1:0]  result
);
    localparam int MAX_TICKS = int'(max_int(window_ticks((2 ** SET_W) - 1, MIN_SAMP_TICKS),
                                            LAT_TICKS));
    localparam int CNT_W     = $clog2(MAX_TICKS);

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             capture;

    adc_phase_ctrl #(
        .SET_W          (SET_W),
        .CH_W           (CH_W),
        .CNT_W          (CNT_W),
        .MIN_SAMP_TICKS (MIN_SAMP_TICKS),
        .LAT_TICKS      (LAT_TICKS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .samp_set  (samp_set),
        .chan      (chan),
        .cnt_zero  (cnt_zero),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .sample_en (sample_en),
        .busy      (busy),
        .capture   (capture),
        .ch_tag    (ch_tag)
    );

    adc_tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .at_zero  (cnt_zero)
    );

    adc_result_latch #(
        .CODE_W (CODE_W),
        .RES_W  (RES_W)
    ) u_res (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .raw_code (raw_code),
        .result   (result),
        .done     (done)
    );
endmodule

// File: rtl/adc_conv_sequencer_chk.sv
module adc_conv_sequencer_chk #(
    parameter int SET_W          = 8,
    parameter int CH_W           = 4,
    parameter int CODE_W         = 12,
    parameter int RES_W          = 16,
    parameter int MIN_SAMP_TICKS = 3,
    parameter int LAT_TICKS      = 25
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [SET_W-1:0]  samp_set,
    input logic [CH_W-1:0]   chan,
    input logic [CODE_W-1:0] raw_code,
    input logic              sample_en,
    input logic              busy,
    input logic              done,
    input logic [CH_W-1:0]   ch_tag,
    input logic [RES_W-1:0]  result
);
    int unsigned      win_len;
    int unsigned      lat_len;
    logic [SET_W-1:0] set_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_len  <= 0;
            lat_len  <= 0;
            set_seen <= '0;
        end else begin
            win_len <= sample_en ? win_len + 1 : 0;
            lat_len <= (busy && !sample_en) ? lat_len + 1 : 0;
            if (!busy && start) begin
                set_seen <= samp_set;
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !sample_en && !done)) else $error("reset"); // R1

    AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> busy) else $error("sample outside busy"); // R2

    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(sample_en)) |-> (win_len == MIN_SAMP_TICKS + 2 * int'(set_seen)))
        else $error("window length"); // R3

    AST_LATENCY_LEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(busy)) |-> (lat_len == LAT_TICKS))
        else $error("latency length"); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))) else $error("done timing"); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done width"); // R5

    AST_RESULT_FORMAT: assert property (@(posedge clk) disable iff (rst)
        done |-> (result == RES_W'($past(raw_code)))) else $error("result"); // R6

    AST_TAG_STABLE_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> $stable(ch_tag)) else $error("tag moved"); // R7
endmodule

bind adc_conv_sequencer adc_conv_sequencer_chk #(
    .SET_W          (SET_W),
    .CH_W           (CH_W),
    .CODE_W         (CODE_W),
    .RES_W          (RES_W),
    .MIN_SAMP_TICKS (MIN_SAMP_TICKS),
    .LAT_TICKS      (LAT_TICKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .samp_set  (samp_set),
    .chan      (chan),
    .raw_code  (raw_code),
    .sample_en (sample_en),
    .busy      (busy),
    .done      (done),
    .ch_tag    (ch_tag),
    .result    (result)
);

// File: tb/test_adc_conv_sequencer.sv
`timescale 1ns/1ps
module test_adc_conv_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  samp_set = '0;
    logic [3:0]  chan = '0;
    logic [11:0] raw_code = '0;
    logic        sample_en, busy, done;
    logic [3:0]  ch_tag;
    logic [15:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    adc_conv_sequencer i_adc_conv_sequencer (
        .clk(clk), .rst(rst), .start(start), .samp_set(samp_set), .chan(chan),
        .raw_code(raw_code), .sample_en(sample_en), .busy(busy), .done(done),
        .ch_tag(ch_tag), .result(result)
    );

    function automatic int exp_window(int s);
        return 3 + 2 * s;
    endfunction

    function automatic logic [15:0] exp_result(logic [11:0] c);
        return {4'b0000, c};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Caller is at a negedge; leaves the bench at the negedge of the done cycle.
    task automatic launch(int s, logic [3:0] ch, logic [11:0] code, bit chained);
        int win;
        int lat;
        start    = 1'b1;
        samp_set = 8'(s);
        chan     = ch;
        raw_code = code;
        @(negedge clk);
        check(chained ? "R9 sample_en" : "R2 sample_en", sample_en, 1);
        check("R2 busy", busy, 1);
        check("R2 ch_tag", ch_tag, ch);
        if (chained) check("R9 done fell", done, 0);
        win = 1;
        lat = 0;
        for (int k = 0; k < 2000; k++) begin
            start    = ($urandom % 3) == 0;   // R7 noise
            samp_set = 8'($urandom);          // R8 noise
            chan     = 4'($urandom);
            @(negedge clk);
            if (!busy) break;
            if (sample_en) win++;
            else lat++;
            check("R7 ch_tag while busy", ch_tag, ch);
        end
        start = 1'b0;
        check("R3 window", win, exp_window(s));
        check("R4 latency", lat, 25);
        if (s == 0) check("R10 total ticks", win + lat, 28);
        check("R5 done", done, 1);
        check("R6 result", result, exp_result(code));
        check("R8 ch_tag at done", ch_tag, ch);
    endtask

    task automatic idle_after(logic [3:0] ch, logic [11:0] code);
        start    = 1'b0;
        raw_code = 12'($urandom);
        @(negedge clk);
        check("R5 done low", done, 0);
        check("R6 result held", result, exp_result(code));
        check("R7 idle busy", busy, 0);
        check("R2 ch_tag held", ch_tag, ch);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 busy", busy, 0);
        check("R1 sample_en", sample_en, 0);
        check("R1 done", done, 0);
        check("R1 result", result, 0);
        check("R1 ch_tag", ch_tag, 0);

        launch(0, 4'h3, 12'hABC, 0);   idle_after(4'h3, 12'hABC);
        launch(255, 4'hF, 12'hFFF, 0); idle_after(4'hF, 12'hFFF);
        launch(1, 4'h0, 12'h001, 0);   idle_after(4'h0, 12'h001);

        // Back-to-back: start held in the done cycle.
        launch(2, 4'h5, 12'h5A5, 0);
        launch(0, 4'h9, 12'h0F0, 1);
        launch(7, 4'hA, 12'h800, 1);
        idle_after(4'hA, 12'h800);

        for (int i = 0; i < 30; i++) begin
            int s;
            logic [3:0]  ch;
            logic [11:0] cd;
            s  = $urandom % 256;
            ch = 4'($urandom);
            cd = 12'($urandom);
            launch(s, ch, cd, 0);
            if ($urandom % 2) idle_after(ch, cd);
            else begin
                int s2;
                s2 = $urandom % 16;
                launch(s2, ~ch, ~cd, 1);
                idle_after(~ch, ~cd);
            end
        end

        // Reset in the middle of a conversion.
        start = 1'b1; samp_set = 8'd10; chan = 4'h6;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid busy", busy, 0);
        check("R1 mid sample_en", sample_en, 0);
        check("R1 mid result", result, 0);
        check("R1 mid ch_tag", ch_tag, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule